// File: doc/BRIEF.md
# Write-Only Two-Wire Command Target

This block is a receive-only target on a standard I2C bus. It listens at one fixed 7-bit address and accepts only write transfers. A valid transfer is the address byte with the write bit, then exactly two data bytes. The block acknowledges the address byte and both data bytes. The two bytes form a 16-bit word that is held internally. The word is copied to the command output only when a later Stop qualifies it. A partial or corrupted transfer therefore never reaches downstream logic, and the output always shows the last complete pair.

Bus inputs are oversampled on the system clock. Each line passes through a two-stage synchronizer and a stable-count filter before Start, Stop and bit edges are detected. The only bus output is an enable for the SDA pull-down. A one-cycle pulse marks every update of the command word. The system reset and the interface-supply undervoltage flag both force the block back to its reset state. The system clock must run at 16 times the SCL rate or faster.

The receiver FSM has eight states:
- `ST_IDLE`: bus idle or transfer ended.
- `ST_ADDR`: collecting the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_HI`: collecting the upper byte.
- `ST_HI_ACK`: acknowledging the upper byte.
- `ST_LO`: collecting the lower byte.
- `ST_LO_ACK`: acknowledging the lower byte.
- `ST_SKIP`: ignoring the rest of a transfer.

Transitions:
- A Start in any state goes to `ST_ADDR` and clears the bit count.
- A Stop in any state goes to `ST_IDLE`.
- `ST_ADDR`, on the SCL fall after the eighth bit, goes to `ST_ADDR_ACK` if the byte matches, or else to `ST_SKIP`.
- `ST_HI` → `ST_HI_ACK` and `ST_LO` → `ST_LO_ACK`, each on the SCL fall after the eighth bit.
- On the SCL fall that ends the acknowledge clock: `ST_ADDR_ACK` → `ST_HI`, `ST_HI_ACK` → `ST_LO`, and `ST_LO_ACK` → `ST_SKIP`.

Top module: `cmd_i2c_target`

## Requirements
- R1: The block acknowledges only the address byte 0x12 (7-bit address 0001001, write bit 0). Every other address byte, including 0x13 (the same address with the read bit set), gets no acknowledge.
- R2: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. Bits are sampled on SCL rising, eight per byte, most significant bit first.
- R3: After the matching address byte and after each of the two data bytes, `sda_pull` is high for the whole ninth SCL clock, including all of its high phase. A third or later data byte gets no acknowledge.
- R4: The first data byte becomes `cmd_word[15:8]` and the second becomes `cmd_word[7:0]`.
- R5: `cmd_word` changes only in a cycle where `cmd_commit` is high. Its reset value is 0xFF00.
- R6: After a complete two-byte write, the next Stop commits the pair. Any number of Repeat-Starts addressed to other targets may come between.
- R7: A Stop that arrives before the second data byte is acknowledged leaves `cmd_word` unchanged and gives no commit.
- R8: If a Repeat-Start readdresses the block and the first new data byte is acknowledged, Stops are ignored until the second new byte is acknowledged. The new pair is then committed on the next Stop.
- R9: While `uvlo` is high, `cmd_word` is 0xFF00 and the receiver is idle. After `uvlo` falls, a full write works normally.
- R10: A Start in the middle of a byte aborts that byte and restarts address reception. The partial data is discarded.
- R11: A pulse on SCL or SDA shorter than FILT_LEN (3) system clocks after synchronization has no effect.
- R12: `cmd_commit` is a single-cycle pulse, and there is one pulse per commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low system reset |
| uvlo | input | 1 | Interface supply below threshold; forces reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | High to pull SDA low (acknowledge) |
| cmd_word | output | 16 | Committed command word |
| cmd_commit | output | 1 | One-cycle pulse when `cmd_word` is updated |

## Verification
Most internal faults show up at the ports within one byte time.
- A wrong FSM state or bit count shows up at the next acknowledge slot. The acknowledge is either missing, or it appears on a byte that should get none. The address sweep and the third-byte test catch this.
- A wrong staging or holding register, or a wrong pending or busy flag, stays hidden until the next Stop. It then appears as a wrong `cmd_word`, a commit that should not happen, or a missing commit.
- The Stop-ordering scenarios are built so that each of those outcomes gives a different result, about six system clocks after the Stop edge.

// File: rtl/cmd_i2c_pkg.sv
package cmd_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CMD_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK,
        ST_SKIP
    } tgt_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

endpackage

// File: rtl/cmd_i2c_glitch_filter.sv
module cmd_i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // Synchronizer chain; idle bus level is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Output follows only after FILT_LEN consecutive differing samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_o <= 1'b1;
            run_q   <= '0;
        end else if (synced == clean_o) begin
            run_q <= '0;
        end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
            clean_o <= synced;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/cmd_i2c_bus_events.sv
module cmd_i2c_bus_events
    import cmd_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt_o.start = scl_q & scl_f & sda_q & ~sda_f;
        evt_o.stop  = scl_q & scl_f & ~sda_q & sda_f;
        evt_o.rise  = ~scl_q & scl_f;
        evt_o.fall  = scl_q & ~scl_f;
    end
endmodule

// File: rtl/cmd_i2c_word_store.sv
module cmd_i2c_word_store
    import cmd_i2c_pkg::*;
#(
    parameter logic [CMD_W-1:0] RESET_WORD = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_take,
    input  logic              lo_take,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              stop_seen,
    output logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_commit,
    output logic              busy
);
    logic [BYTE_W-1:0] stage_hi_q;
    logic [CMD_W-1:0]  hold_q;
    logic              pending_q;
    logic              fire;

    // A Stop commits only a complete pair not overtaken by a new partial one.
    assign fire = stop_seen & pending_q & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_hi_q <= RESET_WORD[CMD_W-1:BYTE_W];
            hold_q     <= RESET_WORD;
            pending_q  <= 1'b0;
            busy       <= 1'b0;
            cmd_word   <= RESET_WORD;
            cmd_commit <= 1'b0;
        end else begin
            cmd_commit <= fire;
            if (hi_take) begin
                stage_hi_q <= byte_in;
                busy       <= 1'b1;
            end
            if (lo_take) begin
                hold_q    <= {stage_hi_q, byte_in};
                pending_q <= 1'b1;
                busy      <= 1'b0;
            end
            if (fire) begin
                cmd_word  <= hold_q;
                pending_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmd_i2c_target.sv
module cmd_i2c_target
    import cmd_i2c_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR    = 7'b0001001,
    parameter int               SYNC_STAGES = 2,
    parameter int               FILT_LEN    = 3,
    parameter logic [CMD_W-1:0] RESET_WORD  = 16'hFF00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull,
    output logic [CMD_W-1:0] cmd_word,
    output logic             cmd_commit
);
    localparam int                CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
    localparam int                N_LINES   = 2;

    logic               rst_any_n;
    logic [N_LINES-1:0] raw_lines, clean_lines;
    logic               scl_f, sda_f;
    bus_evt_t           evt;
    logic               evt_start, evt_stop;

    tgt_state_t         state_q, state_d;
    logic [CNT_W-1:0]   bits_q, bits_d;
    logic [BYTE_W-1:0]  shift_q, shift_d;
    logic               hi_take, lo_take;
    logic               busy;
    logic               byte_full;

    assign rst_any_n = rst_n & ~uvlo;
    assign raw_lines = {scl_i, sda_i};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        cmd_i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_any_n),
            .raw_i  (raw_lines[gi]),
            .clean_o(clean_lines[gi])
        );
    end

    assign scl_f = clean_lines[1];
    assign sda_f = clean_lines[0];

    cmd_i2c_bus_events u_evt (
        .clk  (clk),
        .rst_n(rst_any_n),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .evt_o(evt)
    );

    assign evt_start = evt.start;
    assign evt_stop  = evt.stop;
    assign byte_full = (bits_q == CNT_W'(BYTE_W));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        shift_d = shift_q;
        hi_take = 1'b0;
        lo_take = 1'b0;
        if (evt.start) begin
            state_d = ST_ADDR;
            bits_d  = '0;
        end else if (evt.stop) begin
            state_d = ST_IDLE;
            bits_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_SKIP: ;
                ST_ADDR, ST_HI, ST_LO: begin
                    if (evt.rise && !byte_full) begin
                        shift_d = {shift_q[BYTE_W-2:0], sda_f};
                        bits_d  = bits_q + 1'b1;
                    end else if (evt.fall && byte_full) begin
                        bits_d = '0;
                        if (state_q == ST_ADDR) begin
                            state_d = (shift_q == ADDR_BYTE) ? ST_ADDR_ACK : ST_SKIP;
                        end else if (state_q == ST_HI) begin
                            state_d = ST_HI_ACK;
                            hi_take = 1'b1;
                        end else begin
                            state_d = ST_LO_ACK;
                            lo_take = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: if (evt.fall) state_d = ST_HI;
                ST_HI_ACK:   if (evt.fall) state_d = ST_LO;
                ST_LO_ACK:   if (evt.fall) state_d = ST_SKIP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            shift_q <= shift_d;
        end
    end

    // Output register: pull-down follows the acknowledge states
    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            sda_pull <= 1'b0;
        end else begin
            sda_pull <= (state_d == ST_ADDR_ACK) || (state_d == ST_HI_ACK) ||
                        (state_d == ST_LO_ACK);
        end
    end

    cmd_i2c_word_store #(
        .RESET_WORD(RESET_WORD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_any_n),
        .hi_take   (hi_take),
        .lo_take   (lo_take),
        .byte_in   (shift_q),
        .stop_seen (evt.stop),
        .cmd_word  (cmd_word),
        .cmd_commit(cmd_commit),
        .busy      (busy)
    );
endmodule

// File: rtl/cmd_i2c_target_chk.sv
module cmd_i2c_target_chk (
    input logic        clk,
    input logic        rst_any_n,
    input logic        evt_start,
    input logic        evt_stop,
    input logic        scl_f,
    input logic        busy,
    input logic        sda_pull,
    input logic [15:0] cmd_word,
    input logic        cmd_commit
);
    assert_word_moves_with_commit_R5: assert property (@(posedge clk) disable iff (!rst_any_n)
        !$stable(cmd_word) |-> cmd_commit);

    assert_commit_follows_stop_R6: assert property (@(posedge clk) disable iff (!rst_any_n)
        cmd_commit |-> $past(evt_stop));

    assert_busy_stop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
        (evt_stop && busy) |=> !cmd_commit);

    assert_commit_single_R12: assert property (@(posedge clk) disable iff (!rst_any_n)
        cmd_commit |=> !cmd_commit);

    assert_start_releases_sda_R10: assert property (@(posedge clk) disable iff (!rst_any_n)
        evt_start |=> !sda_pull);

    assert_pull_steady_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_any_n)
        ($past(scl_f) && scl_f && !$past(evt_start) && !$past(evt_stop)) |-> $stable(sda_pull));
endmodule

bind cmd_i2c_target cmd_i2c_target_chk u_chk (
    .clk       (clk),
    .rst_any_n (rst_any_n),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .scl_f     (scl_f),
    .busy      (busy),
    .sda_pull  (sda_pull),
    .cmd_word  (cmd_word),
    .cmd_commit(cmd_commit)
);

// File: tb/cmd_i2c_target_tb.sv
module cmd_i2c_target_tb;
    localparam int Q = 8;   // system clocks per SCL quarter period

    logic        clk = 1'b0;
    logic        rst_n, uvlo, scl_drv, sda_drv;
    logic        sda_pull, cmd_commit;
    logic [15:0] cmd_word;
    wire         sda_line = sda_drv & ~sda_pull;

    int compared = 0, mismatched = 0, commits = 0, wide_pulses = 0;
    logic prev_commit = 1'b0;
    logic done = 1'b0;
    logic [15:0] exp_cmd;
    int exp_commits = 0;

    always #10 clk = ~clk;

    cmd_i2c_target u_dut (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_pull(sda_pull), .cmd_word(cmd_word), .cmd_commit(cmd_commit)
    );

    always @(negedge clk) begin
        if (cmd_commit) commits++;
        if (cmd_commit && prev_commit) wide_pulses++;
        prev_commit = cmd_commit;
    end

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_c(Q);
        scl_drv = 1'b1; wait_c(Q);
        sda_drv = 1'b0; wait_c(Q);
        scl_drv = 1'b0; wait_c(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_c(Q);
        scl_drv = 1'b1; wait_c(Q);
        sda_drv = 1'b1; wait_c(2 * Q + 4);
    endtask

    task automatic bit_out(input logic b, input logic glitch);
        sda_drv = b; wait_c(Q);
        scl_drv = 1'b1; wait_c(Q);
        if (glitch) begin
            sda_drv = ~b; wait_c(2);
            sda_drv = b;  wait_c(Q - 2);
        end else begin
            wait_c(Q);
        end
        scl_drv = 1'b0; wait_c(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i], glitch);
        sda_drv = 1'b1; wait_c(Q);
        scl_drv = 1'b1; wait_c(Q);
        acked = ~sda_line;
        wait_c(Q);
        scl_drv = 1'b0; wait_c(Q);
    endtask

    // Start + address + two data bytes, each acknowledge checked; no Stop.
    task automatic write_pair(input logic [15:0] w, input logic glitch);
        logic a;
        bus_start();
        send_byte(8'h12, glitch, a); chk("R1 address ack", a, 1);
        send_byte(w[15:8], glitch, a); chk("R3 upper byte ack", a, 1);
        send_byte(w[7:0], glitch, a);  chk("R3 lower byte ack", a, 1);
    endtask

    initial begin
        logic a;
        rst_n = 1'b0; uvlo = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1;
        wait_c(5);
        chk("R5 reset word", cmd_word, 16'hFF00);
        chk("R12 no commit in reset", cmd_commit, 0);
        chk("R3 no pull in reset", sda_pull, 0);
        rst_n = 1'b1;
        wait_c(10);
        exp_cmd = 16'hFF00;

        // R2 R4: basic write, byte order
        write_pair(16'hABCD, 1'b0); bus_stop();
        exp_cmd = 16'hABCD; exp_commits++;
        chk("R4 basic word", cmd_word, exp_cmd);
        chk("R2 commit count", commits, exp_commits);

        // R4: sweep of arithmetic patterns
        for (int i = 0; i < 8; i++) begin
            logic [15:0] w;
            w = 16'(i * 16'h3A5B) ^ 16'hC3E1;
            write_pair(w, 1'b0); bus_stop();
            exp_cmd = w; exp_commits++;
            chk("R4 pattern word", cmd_word, exp_cmd);
        end
        chk("R12 commit count after sweep", commits, exp_commits);

        // R1: every 7-bit address with write bit
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, 1'b0, a);
            chk("R1 address sweep ack", a, (ad == 9) ? 1 : 0);
            bus_stop();
        end
        bus_start(); send_byte(8'h13, 1'b0, a); bus_stop();
        chk("R1 read bit no ack", a, 0);
        chk("R5 word unchanged by sweep", cmd_word, exp_cmd);
        chk("R5 no commit by sweep", commits, exp_commits);

        // R3: third byte not acknowledged
        write_pair(16'h5AA5, 1'b0);
        send_byte(8'h77, 1'b0, a);
        chk("R3 third byte no ack", a, 0);
        bus_stop();
        exp_cmd = 16'h5AA5; exp_commits++;
        chk("R4 word after extra byte", cmd_word, exp_cmd);

        // R7: Stop after one data byte ignored
        bus_start(); send_byte(8'h12, 1'b0, a); send_byte(8'h55, 1'b0, a); bus_stop();
        chk("R7 partial stop word", cmd_word, exp_cmd);
        chk("R7 partial stop commits", commits, exp_commits);
        write_pair(16'h1122, 1'b0); bus_stop();
        exp_cmd = 16'h1122; exp_commits++;
        chk("R7 recovery word", cmd_word, exp_cmd);

        // R6: complete pair survives Repeat-Starts to other targets
        write_pair(16'h3C4D, 1'b0);
        bus_start(); send_byte(8'h40, 1'b0, a); send_byte(8'h99, 1'b0, a);
        bus_start(); send_byte(8'h50, 1'b0, a);
        chk("R6 other target no ack", a, 0);
        chk("R6 not yet committed", cmd_word, exp_cmd);
        bus_stop();
        exp_cmd = 16'h3C4D; exp_commits++;
        chk("R6 committed after repeat starts", cmd_word, exp_cmd);

        // R8: readdressed, first byte acked -> Stop ignored
        write_pair(16'hBEEF, 1'b0);
        bus_start(); send_byte(8'h12, 1'b0, a); send_byte(8'h01, 1'b0, a);
        chk("R8 readdress first byte ack", a, 1);
        bus_stop();
        chk("R8 stop ignored word", cmd_word, exp_cmd);
        chk("R8 stop ignored commits", commits, exp_commits);
        write_pair(16'hD00D, 1'b0); bus_stop();
        exp_cmd = 16'hD00D; exp_commits++;
        chk("R8 new pair committed", cmd_word, exp_cmd);

        // R10: Start mid-byte aborts
        bus_start(); send_byte(8'h12, 1'b0, a); send_byte(8'h33, 1'b0, a);
        for (int i = 0; i < 4; i++) bit_out(1'b1, 1'b0);
        write_pair(16'h7788, 1'b0); bus_stop();
        exp_cmd = 16'h7788; exp_commits++;
        chk("R10 restart word", cmd_word, exp_cmd);

        // R11: short glitches on SDA during SCL high are filtered
        write_pair(16'h9A0F, 1'b1); bus_stop();
        exp_cmd = 16'h9A0F; exp_commits++;
        chk("R11 glitched write word", cmd_word, exp_cmd);

        // R9: undervoltage forces reset value
        uvlo = 1'b1; wait_c(4);
        chk("R9 uvlo word", cmd_word, 16'hFF00);
        chk("R9 uvlo no pull", sda_pull, 0);
        uvlo = 1'b0; wait_c(6);
        write_pair(16'h0F1E, 1'b0); bus_stop();
        exp_cmd = 16'h0F1E; exp_commits++;
        chk("R9 write after uvlo", cmd_word, exp_cmd);

        chk("R12 total commits", commits, exp_commits);
        chk("R12 pulse width one cycle", wide_pulses, 0);
        summary();
    end

    initial begin
        repeat (180000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule